// File: doc/BRIEF.md
# Multi-slot carrier interrupt controller

The block merges the interrupt requests of four plug-in module slots onto one host interrupt line. Every slot drives two request lines (line 0 and line 1). A per-slot control register enables each line and decides whether the line behaves as an edge source or a level source. A shared status word records which enabled requests are pending, and it also holds one timeout flag per slot. The host reaches both registers through a simple 16-bit register port.

Level-mode lines are ORed onto the host line. The host line is only re-evaluated when a level-mode pending bit changes. An edge-mode line that becomes pending produces a one-cycle pulse. The host can tell a module to drop a request in two ways. It can write a 1 to that request's pending bit. It can also read the module's interrupt acknowledge location, which the module address decoder reports to this block as a strobe with slot and offset. In both cases the block answers with a one-cycle clear pulse to the module for that line. Timeout detection lies outside the block, which only receives per-slot timeout strobes. The error flags and the reset register are not implemented.

Top module: `carrier_irq_ctl`

## Requirements
- R1: After synchronous reset, `host_irq` and `mod_clear` are 0. Every control register reads 0 and the status word reads 0.
- R2: Register offsets are: 0x00 identifier, 0x02/0x04/0x06/0x08 control of slots 0..3 (slot = offset/2 - 1), 0x0A reset, 0x0C status. A write to a control offset stores `reg_wdata[7:0]`, which reads back on bits 7:0 with bits 15:8 zero. Offsets 0x00 and 0x0A always read 0 and ignore writes. Any other offset reads 0. `reg_rdata` is combinational on the current state.
- R3: Control bit 6+n enables line n of that slot, and request index is 2*slot+n. While a line is enabled, status bit 2*slot+n takes the value that `irq_req[2*slot+n]` had before the clock edge. While it is disabled, that status bit holds its value whatever the request does.
- R4: Control bit 4+n set makes line n an edge line, clear makes it a level line. When a clock edge changes at least one pending bit of a level line, the level part of `host_irq` becomes the OR of all pending bits of level lines. When no such bit changes, the level part holds its value.
- R5: An edge line whose pending bit goes 0 to 1 at a clock edge raises `host_irq` for exactly the following cycle. It holds no level state for that line.
- R6: A status write with `reg_wdata[2*slot+n]` = 1 pulses `mod_clear[2*slot+n]` for the one cycle after the write edge. The pending bit itself is not changed by the write.
- R7: `slot_timeout[s]` sets status bit 12+s. A status write with bit 12+s = 1 clears it. If both happen in the same cycle, the set wins.
- R8: Status bits 11:8 always read 0, and writing 1s to them has no effect.
- R9: An acknowledge strobe with `ack_off` = 0 refers to line 0 of `ack_slot`, and `ack_off` = 2 refers to line 1. It pulses that line's `mod_clear` bit in the next cycle only if the line is pending and in level mode. Any other offset, a non-pending line or an edge line gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_req | input | 8 | Module request lines, index 2*slot+line |
| ack_valid | input | 1 | Interrupt-space read strobe from the address decoder |
| ack_slot | input | 2 | Slot of the acknowledge read |
| ack_off | input | 6 | Offset of the acknowledge read within the interrupt space |
| slot_timeout | input | 4 | Per-slot timeout strobes |
| mod_clear | output | 8 | One-cycle request clear pulses to the modules |
| host_irq | output | 1 | Host interrupt |

## Verification
A pending bit stuck or copied at the wrong time shows up on the status read at the next sample, and a level-mode bit also shows on `host_irq` in that same cycle. A stale level state is only visible when `host_irq` disagrees after the next level-line change. So the bench changes request lines often and in every mix of modes and enables. Clear pulses are checked every cycle, so a wrong line index, or an acknowledge that ignores mode or pending state, is seen one cycle after the strobe.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;
    localparam int NSLOT    = 4;
    localparam int NLINE    = 2;
    localparam int NREQ     = NSLOT * NLINE;
    localparam int SW       = $clog2(NSLOT);
    localparam int DW       = 16;
    localparam int AW       = 8;
    localparam int OFFW     = 6;
    localparam int CTRLW    = 8;
    localparam int TOUT_LSB = 12;

    localparam logic [AW-1:0] A_IDENT = 8'h00;
    localparam logic [AW-1:0] A_RSTR  = 8'h0A;
    localparam logic [AW-1:0] A_STAT  = 8'h0C;

    typedef struct packed {
        logic [NLINE-1:0] en;
        logic [NLINE-1:0] edg;
        logic             err_ie;
        logic             tout_ie;
        logic             recover;
        logic             clk_rate;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_CTRL,
        SEL_RSTR,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic [SW-1:0]   slot;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [AW-1:0] a);
        reg_dec_t d;
        d.sel  = SEL_NONE;
        d.slot = '0;
        if (a == A_IDENT) begin
            d.sel = SEL_IDENT;
        end else if (a == A_RSTR) begin
            d.sel = SEL_RSTR;
        end else if (a == A_STAT) begin
            d.sel = SEL_STAT;
        end else if (!a[0] && a >= AW'(2) && a <= AW'(2 * NSLOT)) begin
            d.sel  = SEL_CTRL;
            d.slot = SW'((a >> 1) - AW'(1));
        end
        return d;
    endfunction
endpackage

// File: rtl/carrier_irq_regs.sv
module carrier_irq_regs
    import carrier_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    input  logic [NREQ-1:0]       pend_q,
    input  logic [NSLOT-1:0]      tout_q,
    output logic [DW-1:0]         reg_rdata,
    output logic [NREQ-1:0]       en_mask,
    output logic [NREQ-1:0]       edge_mask,
    output logic                  stat_wr
);
    ctrl_t [NSLOT-1:0] ctrl_q;
    reg_dec_t          dec;
    logic [DW-1:0]     status_word;

    assign dec     = decode_addr(reg_addr);
    assign stat_wr = reg_wr && (dec.sel == SEL_STAT);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[s] <= '0;
            end else if (reg_wr && dec.sel == SEL_CTRL && dec.slot == SW'(s)) begin
                ctrl_q[s] <= ctrl_t'(reg_wdata[CTRLW-1:0]);
            end
        end
        for (genvar n = 0; n < NLINE; n++) begin : g_line
            assign en_mask[s*NLINE+n]   = ctrl_q[s].en[n];
            assign edge_mask[s*NLINE+n] = ctrl_q[s].edg[n];
        end
    end

    always_comb begin
        status_word = '0;
        status_word[NREQ-1:0] = pend_q;
        status_word[TOUT_LSB +: NSLOT] = tout_q;
    end

    always_comb begin
        case (dec.sel)
            SEL_CTRL: reg_rdata = {{(DW-CTRLW){1'b0}}, ctrl_q[dec.slot]};
            SEL_STAT: reg_rdata = status_word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/carrier_irq_status.sv
module carrier_irq_status
    import carrier_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREQ-1:0]       irq_req,
    input  logic [NREQ-1:0]       en_mask,
    input  logic [NREQ-1:0]       edge_mask,
    input  logic                  stat_wr,
    input  logic [DW-1:0]         reg_wdata,
    input  logic                  ack_valid,
    input  logic [SW-1:0]         ack_slot,
    input  logic [OFFW-1:0]       ack_off,
    input  logic [NSLOT-1:0]      slot_timeout,
    output logic [NREQ-1:0]       pend_q,
    output logic [NREQ-1:0]       pend_d,
    output logic [NSLOT-1:0]      tout_q,
    output logic [NREQ-1:0]       mod_clear
);
    logic [NREQ-1:0]  wr_clr;
    logic [NREQ-1:0]  ack_clr;
    logic [NSLOT-1:0] tout_clr;

    for (genvar i = 0; i < NREQ; i++) begin : g_pend
        assign pend_d[i] = en_mask[i] ? irq_req[i] : pend_q[i];
    end

    assign wr_clr   = stat_wr ? reg_wdata[NREQ-1:0] : '0;
    assign tout_clr = stat_wr ? reg_wdata[TOUT_LSB +: NSLOT] : '0;

    always_comb begin
        ack_clr = '0;
        if (ack_valid) begin
            for (int n = 0; n < NLINE; n++) begin
                if (ack_off == OFFW'(2 * n)) begin
                    ack_clr[int'(ack_slot)*NLINE + n] = 1'b1;
                end
            end
        end
        ack_clr = ack_clr & pend_q & ~edge_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            tout_q    <= '0;
            mod_clear <= '0;
        end else begin
            pend_q    <= pend_d;
            tout_q    <= (tout_q & ~tout_clr) | slot_timeout;
            mod_clear <= wr_clr | ack_clr;
        end
    end
endmodule

// File: rtl/carrier_irq_combine.sv
module carrier_irq_combine
    import carrier_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREQ-1:0]       pend_q,
    input  logic [NREQ-1:0]       pend_d,
    input  logic [NREQ-1:0]       edge_mask,
    output logic                  level_q,
    output logic                  host_irq
);
    logic pulse_q;
    logic lvl_changed;
    logic lvl_any;
    logic edge_rise;

    assign lvl_changed = |((pend_d ^ pend_q) & ~edge_mask);
    assign lvl_any     = |(pend_d & ~edge_mask);
    assign edge_rise   = |(pend_d & ~pend_q & edge_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (lvl_changed) begin
                level_q <= lvl_any;
            end
            pulse_q <= edge_rise;
        end
    end

    assign host_irq = level_q | pulse_q;
endmodule

// File: rtl/carrier_irq_ctl.sv
module carrier_irq_ctl
    import carrier_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic [NREQ-1:0]       irq_req,
    input  logic                  ack_valid,
    input  logic [SW-1:0]         ack_slot,
    input  logic [OFFW-1:0]       ack_off,
    input  logic [NSLOT-1:0]      slot_timeout,
    output logic [NREQ-1:0]       mod_clear,
    output logic                  host_irq
);
    logic [NREQ-1:0]  pend_q;
    logic [NREQ-1:0]  pend_d;
    logic [NSLOT-1:0] tout_q;
    logic [NREQ-1:0]  en_mask;
    logic [NREQ-1:0]  edge_mask;
    logic             stat_wr;
    logic             level_q;

    carrier_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .tout_q    (tout_q),
        .reg_rdata (reg_rdata),
        .en_mask   (en_mask),
        .edge_mask (edge_mask),
        .stat_wr   (stat_wr)
    );

    carrier_irq_status u_status (
        .clk          (clk),
        .rst          (rst),
        .irq_req      (irq_req),
        .en_mask      (en_mask),
        .edge_mask    (edge_mask),
        .stat_wr      (stat_wr),
        .reg_wdata    (reg_wdata),
        .ack_valid    (ack_valid),
        .ack_slot     (ack_slot),
        .ack_off      (ack_off),
        .slot_timeout (slot_timeout),
        .pend_q       (pend_q),
        .pend_d       (pend_d),
        .tout_q       (tout_q),
        .mod_clear    (mod_clear)
    );

    carrier_irq_combine u_combine (
        .clk       (clk),
        .rst       (rst),
        .pend_q    (pend_q),
        .pend_d    (pend_d),
        .edge_mask (edge_mask),
        .level_q   (level_q),
        .host_irq  (host_irq)
    );
endmodule

// File: rtl/carrier_irq_chk.sv
module carrier_irq_chk
    import carrier_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_rdata,
    input logic              ack_valid,
    input logic [NSLOT-1:0]  slot_timeout,
    input logic [NREQ-1:0]   mod_clear,
    input logic              host_irq,
    input logic [NREQ-1:0]   pend_q,
    input logic [NREQ-1:0]   en_mask,
    input logic [NSLOT-1:0]  tout_q,
    input logic              level_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!host_irq && mod_clear == '0 && pend_q == '0 && tout_q == '0));

    assert_clear_source_R6: assert property (@(posedge clk) disable iff (rst)
        (mod_clear != '0) |-> ($past(reg_wr) && $past(reg_addr) == A_STAT) || $past(ack_valid));

    assert_level_holds_R4: assert property (@(posedge clk) disable iff (rst)
        $stable(pend_q) |-> $stable(level_q));

    assert_err_bits_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_STAT) |-> (reg_rdata[11:8] == 4'h0));

    for (genvar i = 0; i < NREQ; i++) begin : g_pend_chk
        assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (rst)
            !en_mask[i] |=> $stable(pend_q[i]));
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_tout_chk
        assert_timeout_sets_R7: assert property (@(posedge clk) disable iff (rst)
            slot_timeout[s] |=> tout_q[s]);
    end
endmodule

bind carrier_irq_ctl carrier_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .ack_valid    (ack_valid),
    .slot_timeout (slot_timeout),
    .mod_clear    (mod_clear),
    .host_irq     (host_irq),
    .pend_q       (pend_q),
    .en_mask      (en_mask),
    .tout_q       (tout_q),
    .level_q      (level_q)
);

// File: tb/carrier_irq_ctl_tb.sv
module carrier_irq_ctl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_req;
    logic        ack_valid;
    logic [1:0]  ack_slot;
    logic [5:0]  ack_off;
    logic [3:0]  slot_timeout;
    logic [7:0]  mod_clear;
    logic        host_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] m_ctrl [4];
    logic [7:0] m_pend;
    logic [3:0] m_tout;
    logic       m_lvl;

    always #10 clk = ~clk;

    carrier_irq_ctl u_dut (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_req (irq_req),
        .ack_valid (ack_valid), .ack_slot (ack_slot), .ack_off (ack_off),
        .slot_timeout (slot_timeout), .mod_clear (mod_clear), .host_irq (host_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] emask();
        logic [7:0] m;
        for (int s = 0; s < 4; s++) begin
            m[2*s]   = m_ctrl[s][4];
            m[2*s+1] = m_ctrl[s][5];
        end
        return m;
    endfunction

    function automatic logic [7:0] enmask();
        logic [7:0] m;
        for (int s = 0; s < 4; s++) begin
            m[2*s]   = m_ctrl[s][6];
            m[2*s+1] = m_ctrl[s][7];
        end
        return m;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        if (a == 8'h0C) return {m_tout, 4'h0, m_pend};
        if (a == 8'h02 || a == 8'h04 || a == 8'h06 || a == 8'h08)
            return {8'h00, m_ctrl[a/2-1]};
        return 16'h0000;
    endfunction

    // One clock: drive at negedge, update the model, sample at the next negedge.
    task automatic step(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                        input logic [7:0] req, input logic av, input logic [1:0] asl,
                        input logic [5:0] aof, input logic [3:0] to);
        logic [7:0] em, en, pn, clr;
        logic       pulse;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; irq_req = req;
        ack_valid = av; ack_slot = asl; ack_off = aof; slot_timeout = to;
        em = emask(); en = enmask();
        pn = (en & req) | (~en & m_pend);
        clr = 8'h00;
        if (wr && a == 8'h0C) clr = wd[7:0];
        if (av && (aof == 6'd0 || aof == 6'd2))
            clr[2*asl + aof/2] = clr[2*asl + aof/2] | (m_pend[2*asl + aof/2] & ~em[2*asl + aof/2]);
        if (|((pn ^ m_pend) & ~em)) m_lvl = |(pn & ~em);
        pulse = |(pn & ~m_pend & em);
        m_pend = pn;
        m_tout = (m_tout & ~((wr && a == 8'h0C) ? wd[15:12] : 4'h0)) | to;
        if (wr && (a == 8'h02 || a == 8'h04 || a == 8'h06 || a == 8'h08))
            m_ctrl[a/2-1] = wd[7:0];
        @(negedge clk);
        check(pulse ? "R5 host_irq" : "R4 host_irq", {15'd0, host_irq}, {15'd0, m_lvl | pulse});
        check((wr && a == 8'h0C) ? "R6 mod_clear" : "R9 mod_clear", {8'd0, mod_clear}, {8'd0, clr});
        check((a == 8'h0C) ? "R3 R7 R8 status" : "R2 rdata", reg_rdata, exp_rd(a));
    endtask

    task automatic rd(input logic [7:0] a);
        step(1'b0, a, 16'h0, irq_req, 1'b0, 2'd0, 6'd0, 4'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        step(1'b1, a, d, irq_req, 1'b0, 2'd0, 6'd0, 4'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed;
        logic [7:0]  addrs [9];
        logic [7:0]  req;
        seed = 32'd1234;
        void'($urandom(seed));
        addrs = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h0C, 8'h0E, 8'h03};
        for (int s = 0; s < 4; s++) m_ctrl[s] = 8'h00;
        m_pend = 8'h00; m_tout = 4'h0; m_lvl = 1'b0;
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; irq_req = 8'hFF;
        ack_valid = 0; ack_slot = 0; ack_off = 0; slot_timeout = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 host_irq", {15'd0, host_irq}, 16'h0);
        check("R1 mod_clear", {8'd0, mod_clear}, 16'h0);
        reg_addr = 8'h0C; #1;
        check("R1 status", reg_rdata, 16'h0);
        reg_addr = 8'h06; #1;
        check("R1 ctrl", reg_rdata, 16'h0);
        rst = 1'b0; irq_req = 8'h00;

        // R3: disabled requests are ignored
        step(1'b0, 8'h0C, 16'h0, 8'hFF, 1'b0, 2'd0, 6'd0, 4'h0);
        check("R3 disabled ignored", reg_rdata, 16'h0000);
        // R2: control readback, identifier, reset register, unmapped
        wr(8'h06, 16'hAB3D);
        check("R2 ctrl store", reg_rdata, 16'h003D);
        wr(8'h00, 16'hFFFF); check("R2 ident", reg_rdata, 16'h0);
        wr(8'h0A, 16'hFFFF); check("R2 reset reg", reg_rdata, 16'h0);
        rd(8'h0E); check("R2 unmapped", reg_rdata, 16'h0);
        wr(8'h06, 16'h0000);

        // R4: slot 0 line 1 level mode
        step(1'b0, 8'h0C, 16'h0, 8'h00, 1'b0, 2'd0, 6'd0, 4'h0);
        wr(8'h02, 16'h0080);
        step(1'b0, 8'h0C, 16'h0, 8'h02, 1'b0, 2'd0, 6'd0, 4'h0);
        check("R4 level asserted", {15'd0, host_irq}, 16'h1);
        check("R3 pending bit1", reg_rdata, 16'h0002);
        // R9: edge-ack at offset 1 does nothing, offset 2 clears
        step(1'b0, 8'h0C, 16'h0, 8'h02, 1'b1, 2'd0, 6'd1, 4'h0);
        check("R9 bad offset", {8'd0, mod_clear}, 16'h0);
        step(1'b0, 8'h0C, 16'h0, 8'h02, 1'b1, 2'd0, 6'd2, 4'h0);
        check("R9 level ack", {8'd0, mod_clear}, 16'h0002);
        step(1'b0, 8'h0C, 16'h0, 8'h00, 1'b0, 2'd0, 6'd0, 4'h0);
        check("R4 level released", {15'd0, host_irq}, 16'h0);

        // R5: slot 1 line 0 edge mode (enable bit6, edge bit4)
        wr(8'h04, 16'h0050);
        step(1'b0, 8'h0C, 16'h0, 8'h04, 1'b0, 2'd0, 6'd0, 4'h0);
        check("R5 pulse on", {15'd0, host_irq}, 16'h1);
        rd(8'h0C);
        check("R5 pulse one cycle", {15'd0, host_irq}, 16'h0);
        step(1'b0, 8'h0C, 16'h0, 8'h04, 1'b1, 2'd1, 6'd0, 4'h0);
        check("R9 edge no ack", {8'd0, mod_clear}, 16'h0);
        // R6: status write asks module to drop, pending unchanged
        wr(8'h0C, 16'h0F04);
        check("R6 clear pulse", {8'd0, mod_clear}, 16'h0004);
        check("R8 err bits", reg_rdata, 16'h0004);
        // R7: timeout set, set wins over clear, then clear
        step(1'b0, 8'h0C, 16'h0, 8'h00, 1'b0, 2'd0, 6'd0, 4'h4);
        check("R7 timeout set", reg_rdata, 16'h4000);
        step(1'b1, 8'h0C, 16'h4000, 8'h00, 1'b0, 2'd0, 6'd0, 4'h4);
        check("R7 set wins", reg_rdata, 16'h4000);
        wr(8'h0C, 16'h4000);
        check("R7 timeout cleared", reg_rdata, 16'h0000);

        // Random phase
        req = 8'h00;
        for (int k = 0; k < 4000; k++) begin
            logic        w;
            logic [7:0]  a;
            logic [15:0] d;
            logic        av;
            logic [5:0]  ao;
            logic [3:0]  to;
            w  = ($urandom % 5) == 0;
            a  = addrs[$urandom % 9];
            d  = 16'($urandom);
            for (int b = 0; b < 8; b++) if (($urandom % 8) == 0) req[b] = ~req[b];
            av = ($urandom % 6) == 0;
            case ($urandom % 4)
                0: ao = 6'd0;
                1: ao = 6'd2;
                2: ao = 6'd1;
                default: ao = 6'd4;
            endcase
            to = (($urandom % 20) == 0) ? 4'($urandom) : 4'h0;
            step(w, a, d, req, av, 2'($urandom), ao, to);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule